// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox

This block keeps one single-entry mailbox slot for each CPU, used for interrupts that arrive as messages from an external bus. A message names a target CPU and carries a 5-bit source id and two 64-bit data words. If the target's slot is free, the block accepts the message in the same cycle, stores the source id and both data words, marks the slot busy, and one cycle later posts an interrupt to that CPU. The vector it posts comes from a single programmable register that all slots share. If the slot is already busy, the block refuses the message and changes nothing, so the sender can retry later.

Software reaches the mailbox through a simple register port. Each slot has an indexed view of its data words and its status. A second set of alias offsets picks the slot of whichever CPU issues the access, using the CPU id that comes with the request. Software reads the captured words and the status, then writes the busy bit low to free the slot. Read data is returned one cycle after the request.

Top module: `irq_mailbox`

## Requirements
- R1: After reset every slot is free, its source id and data words read as zero, the shared vector reads zero, and neither post_valid_o nor rsp_valid_o is high.
- R2: A message to a free slot is accepted: msg_accept_o is high in the same cycle as msg_valid_i, and from the next cycle the slot is busy and holds the message's source id, data word 0 and data word 1.
- R3: A message to a busy slot is refused: msg_accept_o is low, no interrupt is posted, and the slot's busy bit, source id and data words keep their values.
- R4: One cycle after each accepted message, post_valid_o is high for one cycle with post_cpu_o set to the target CPU and post_vec_o set to the shared vector as it stood when the message was accepted. post_valid_o is never high otherwise.
- R5: A status word reads with the busy bit at bit 5, the source id in bits 4:0, and zero in all other bits.
- R6: A write to a status word loads the busy bit from write-data bit 5 only. The stored source id does not change.
- R7: Indexed views: data word 0 of CPU n is at offset 0x000 + 8n, data word 1 at 0x100 + 8n, and the status word at 0x200 + 8n.
- R8: Alias offsets 0x300 (data word 0), 0x308 (data word 1) and 0x310 (status) reach the slot of the CPU given on req_cpu_i, for both reads and status writes.
- R9: The shared vector register is at offset 0x400. A write loads write-data bits 5:0, a read returns them in bits 5:0, and every post uses it.
- R10: Data words cannot be written by software, so writes to their offsets have no effect. A read from an offset that maps to nothing returns zero.
- R11: When a message is accepted in the same cycle as a software write to that slot's status word, the message wins and the slot ends busy with the new source id.
- R12: rsp_valid_o is high exactly one cycle after each read request, and rsp_rdata_o shows the state from before any update made in the request's cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Incoming message strobe |
| msg_cpu_i | input | 3 | Target CPU of the message |
| msg_src_i | input | 5 | Source id of the message |
| msg_d0_i | input | 64 | Message data word 0 |
| msg_d1_i | input | 64 | Message data word 1 |
| msg_accept_o | output | 1 | Message accepted (combinational); low means refused |
| post_valid_o | output | 1 | Interrupt post strobe |
| post_cpu_o | output | 3 | CPU that receives the post |
| post_vec_o | output | 6 | Vector sent with the post |
| req_valid_i | input | 1 | Register access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset of the register |
| req_cpu_i | input | 3 | CPU issuing the access; selects the slot for alias offsets |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 64 | Read data |

## Verification
A busy bit stuck high shows on the next message to that slot as a refusal with no post, and a bit stuck low shows as a second capture that overwrites data still waiting to be read. Either fault is visible within one cycle. A source id or data word that was stored wrong, or a slot that was indexed wrong, shows on the first read of that slot after the capture, through the indexed view or the alias view. Writes that land in the same cycle as a capture, and reads that overlap a capture, are driven on purpose so that a wrong update priority or a wrong read timing shows up in the returned word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_DATA0,
    TGT_DATA1,
    TGT_STAT,
    TGT_VEC
  } tgt_e;

  // bank selects are addr[ADDR_W-1:8]
  localparam int BANK_DATA0   = 0;
  localparam int BANK_DATA1   = 1;
  localparam int BANK_STAT    = 2;
  localparam int OFS_ALIAS_D0 = 'h300;
  localparam int OFS_ALIAS_D1 = 'h308;
  localparam int OFS_ALIAS_ST = 'h310;
  localparam int OFS_VEC      = 'h400;

endpackage

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode
  import mbx_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int ADDR_W   = 12,
  parameter int CPU_W    = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CPU_W-1:0]  req_cpu_i,
  output tgt_e              tgt_o,
  output logic [CPU_W-1:0]  idx_o
);

  localparam int BANK_W = ADDR_W - 8;

  logic [BANK_W-1:0] bank;
  logic [4:0]        entry;
  logic              aligned;
  logic              entry_ok;
  logic              cpu_ok;

  always_comb begin
    bank     = addr_i[ADDR_W-1:8];
    entry    = addr_i[7:3];
    aligned  = (addr_i[2:0] == 3'd0);
    entry_ok = int'(entry) < NUM_CPUS;
    cpu_ok   = int'(req_cpu_i) < NUM_CPUS;
    tgt_o    = TGT_NONE;
    idx_o    = entry[CPU_W-1:0];

    if (aligned && entry_ok) begin
      if (bank == BANK_W'(BANK_DATA0))      tgt_o = TGT_DATA0;
      else if (bank == BANK_W'(BANK_DATA1)) tgt_o = TGT_DATA1;
      else if (bank == BANK_W'(BANK_STAT))  tgt_o = TGT_STAT;
    end

    // alias views follow the requesting CPU
    if (cpu_ok) begin
      if (addr_i == ADDR_W'(OFS_ALIAS_D0)) begin
        tgt_o = TGT_DATA0;
        idx_o = req_cpu_i;
      end else if (addr_i == ADDR_W'(OFS_ALIAS_D1)) begin
        tgt_o = TGT_DATA1;
        idx_o = req_cpu_i;
      end else if (addr_i == ADDR_W'(OFS_ALIAS_ST)) begin
        tgt_o = TGT_STAT;
        idx_o = req_cpu_i;
      end
    end

    if (addr_i == ADDR_W'(OFS_VEC)) tgt_o = TGT_VEC;
  end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DATA_W = 64,
  parameter int SRC_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [DATA_W-1:0] d0_i,
  input  logic [DATA_W-1:0] d1_i,
  input  logic              sw_we_i,
  input  logic              sw_busy_i,
  output logic              busy_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [DATA_W-1:0] d0_o,
  output logic [DATA_W-1:0] d1_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      src_o  <= '0;
      d0_o   <= '0;
      d1_o   <= '0;
    end else if (cap_i) begin
      // capture outranks a same-cycle software write
      busy_o <= 1'b1;
      src_o  <= src_i;
      d0_o   <= d0_i;
      d1_o   <= d1_i;
    end else if (sw_we_i) begin
      busy_o <= sw_busy_i;
    end
  end

endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux
  import mbx_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int CPU_W    = 3,
  parameter int DATA_W   = 64,
  parameter int SRC_W    = 5,
  parameter int VEC_W    = 6
) (
  input  tgt_e                             tgt_i,
  input  logic [CPU_W-1:0]                 idx_i,
  input  logic [NUM_CPUS-1:0]              busy_i,
  input  logic [NUM_CPUS-1:0][SRC_W-1:0]   src_i,
  input  logic [NUM_CPUS-1:0][DATA_W-1:0]  d0_i,
  input  logic [NUM_CPUS-1:0][DATA_W-1:0]  d1_i,
  input  logic [VEC_W-1:0]                 vec_i,
  output logic [DATA_W-1:0]                rdata_o
);

  always_comb begin
    rdata_o = '0;
    case (tgt_i)
      TGT_DATA0: rdata_o = d0_i[idx_i];
      TGT_DATA1: rdata_o = d1_i[idx_i];
      TGT_STAT: begin
        rdata_o[SRC_W]     = busy_i[idx_i];
        rdata_o[SRC_W-1:0] = src_i[idx_i];
      end
      TGT_VEC:  rdata_o[VEC_W-1:0] = vec_i;
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_mailbox.sv
module irq_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int DATA_W   = 64,
  parameter int SRC_W    = 5,
  parameter int VEC_W    = 6,
  parameter int ADDR_W   = 12,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [CPU_W-1:0]  msg_cpu_i,
  input  logic [SRC_W-1:0]  msg_src_i,
  input  logic [DATA_W-1:0] msg_d0_i,
  input  logic [DATA_W-1:0] msg_d1_i,
  output logic              msg_accept_o,
  output logic              post_valid_o,
  output logic [CPU_W-1:0]  post_cpu_o,
  output logic [VEC_W-1:0]  post_vec_o,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CPU_W-1:0]  req_cpu_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  logic [NUM_CPUS-1:0]             busy_vec;
  logic [NUM_CPUS-1:0][SRC_W-1:0]  src_vec;
  logic [NUM_CPUS-1:0][DATA_W-1:0] d0_vec;
  logic [NUM_CPUS-1:0][DATA_W-1:0] d1_vec;
  logic [VEC_W-1:0]                vec_q;

  tgt_e              tgt;
  logic [CPU_W-1:0]  idx;
  logic [DATA_W-1:0] mux_rdata;
  logic              msg_in_range;
  logic              do_write;
  logic              do_read;
  logic              unused_wdata;

  assign unused_wdata = ^req_wdata_i;

  mbx_addr_decode #(
    .NUM_CPUS(NUM_CPUS),
    .ADDR_W  (ADDR_W),
    .CPU_W   (CPU_W)
  ) u_dec (
    .addr_i   (req_addr_i),
    .req_cpu_i(req_cpu_i),
    .tgt_o    (tgt),
    .idx_o    (idx)
  );

  assign msg_in_range = int'(msg_cpu_i) < NUM_CPUS;
  assign msg_accept_o = msg_valid_i && msg_in_range && !busy_vec[msg_cpu_i];
  assign do_write     = req_valid_i && req_write_i;
  assign do_read      = req_valid_i && !req_write_i;

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_slot
    logic cap;
    logic sw_we;
    assign cap   = msg_accept_o && (msg_cpu_i == CPU_W'(i));
    assign sw_we = do_write && (tgt == TGT_STAT) && (idx == CPU_W'(i));

    mbx_slot #(
      .DATA_W(DATA_W),
      .SRC_W (SRC_W)
    ) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cap_i    (cap),
      .src_i    (msg_src_i),
      .d0_i     (msg_d0_i),
      .d1_i     (msg_d1_i),
      .sw_we_i  (sw_we),
      .sw_busy_i(req_wdata_i[SRC_W]),
      .busy_o   (busy_vec[i]),
      .src_o    (src_vec[i]),
      .d0_o     (d0_vec[i]),
      .d1_o     (d1_vec[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
    end else if (do_write && tgt == TGT_VEC) begin
      vec_q <= req_wdata_i[VEC_W-1:0];
    end
  end

  // post stage: one cycle behind the accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_valid_o <= 1'b0;
      post_cpu_o   <= '0;
      post_vec_o   <= '0;
    end else begin
      post_valid_o <= msg_accept_o;
      if (msg_accept_o) begin
        post_cpu_o <= msg_cpu_i;
        post_vec_o <= vec_q;
      end
    end
  end

  mbx_rd_mux #(
    .NUM_CPUS(NUM_CPUS),
    .CPU_W   (CPU_W),
    .DATA_W  (DATA_W),
    .SRC_W   (SRC_W),
    .VEC_W   (VEC_W)
  ) u_mux (
    .tgt_i  (tgt),
    .idx_i  (idx),
    .busy_i (busy_vec),
    .src_i  (src_vec),
    .d0_i   (d0_vec),
    .d1_i   (d1_vec),
    .vec_i  (vec_q),
    .rdata_o(mux_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= do_read;
      if (do_read) rsp_rdata_o <= mux_rdata;
    end
  end

endmodule

// File: rtl/irq_mailbox_checker.sv
module irq_mailbox_checker #(
  parameter int NUM_CPUS = 8,
  parameter int DATA_W   = 64,
  parameter int VEC_W    = 6,
  parameter int CPU_W    = 3
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            msg_valid_i,
  input logic [CPU_W-1:0]                msg_cpu_i,
  input logic                            msg_accept_o,
  input logic                            post_valid_o,
  input logic [CPU_W-1:0]                post_cpu_o,
  input logic [VEC_W-1:0]                post_vec_o,
  input logic                            req_valid_i,
  input logic                            req_write_i,
  input logic                            rsp_valid_o,
  input logic [VEC_W-1:0]                vec_q_i,
  input logic [NUM_CPUS-1:0]             busy_vec_i,
  input logic [NUM_CPUS-1:0][DATA_W-1:0] d0_vec_i
);

  assert_capture_sets_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_accept_o |=> busy_vec_i[$past(msg_cpu_i)]);

  assert_refusal_keeps_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && !msg_accept_o) |=> (d0_vec_i == $past(d0_vec_i)));

  assert_post_follows_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_accept_o |=> (post_valid_o && post_cpu_o == $past(msg_cpu_i)
                      && post_vec_o == $past(vec_q_i)));

  assert_no_stray_post_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_accept_o |=> !post_valid_o);

  assert_read_response_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  assert_no_stray_response_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o);

endmodule

bind irq_mailbox irq_mailbox_checker #(
  .NUM_CPUS(NUM_CPUS),
  .DATA_W  (DATA_W),
  .VEC_W   (VEC_W),
  .CPU_W   (CPU_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msg_valid_i (msg_valid_i),
  .msg_cpu_i   (msg_cpu_i),
  .msg_accept_o(msg_accept_o),
  .post_valid_o(post_valid_o),
  .post_cpu_o  (post_cpu_o),
  .post_vec_o  (post_vec_o),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .rsp_valid_o (rsp_valid_o),
  .vec_q_i     (vec_q),
  .busy_vec_i  (busy_vec),
  .d0_vec_i    (d0_vec)
);

// File: tb/irq_mailbox_tb_top.sv
`timescale 1ns/1ps
module irq_mailbox_tb_top;

  localparam int NC = 8;
  localparam int CW = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msg_valid_i = 1'b0;
  logic [CW-1:0] msg_cpu_i = '0;
  logic [4:0]  msg_src_i = '0;
  logic [63:0] msg_d0_i = '0;
  logic [63:0] msg_d1_i = '0;
  logic        msg_accept_o;
  logic        post_valid_o;
  logic [CW-1:0] post_cpu_o;
  logic [5:0]  post_vec_o;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [CW-1:0] req_cpu_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [63:0] rsp_rdata_o;

  always #4 clk = ~clk;

  irq_mailbox dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .msg_valid_i(msg_valid_i), .msg_cpu_i(msg_cpu_i), .msg_src_i(msg_src_i),
    .msg_d0_i(msg_d0_i), .msg_d1_i(msg_d1_i), .msg_accept_o(msg_accept_o),
    .post_valid_o(post_valid_o), .post_cpu_o(post_cpu_o), .post_vec_o(post_vec_o),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_cpu_i(req_cpu_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o)
  );

  int total = 0;
  int bad = 0;

  // reference model from the requirements
  logic          busy_m [NC];
  logic [4:0]    src_m  [NC];
  logic [63:0]   d0_m   [NC];
  logic [63:0]   d1_m   [NC];
  logic [5:0]    vec_m;

  logic [63:0]   rd_q [$];
  string         rd_tag_q [$];
  logic [CW+5:0] post_q [$];
  string         post_tag_q [$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] stat_word(int c);
    return {58'd0, busy_m[c], src_m[c]};
  endfunction

  // R7 R8 R9 R10 address map
  function automatic logic [63:0] mread(logic [11:0] a, int c);
    if (a == 12'h300) return d0_m[c];
    if (a == 12'h308) return d1_m[c];
    if (a == 12'h310) return stat_word(c);
    if (a == 12'h400) return {58'd0, vec_m};
    if (a[2:0] == 3'd0 && a[7:3] < NC) begin
      if (a[11:8] == 4'd0) return d0_m[a[7:3]];
      if (a[11:8] == 4'd1) return d1_m[a[7:3]];
      if (a[11:8] == 4'd2) return stat_word(int'(a[7:3]));
    end
    return 64'd0;
  endfunction

  // one cycle of stimulus, started and ended at a falling edge
  task automatic tick_io(input bit mv, input logic [CW-1:0] mc, input logic [4:0] ms,
                         input logic [63:0] m0, input logic [63:0] m1,
                         input bit rv, input bit rw, input logic [11:0] ra,
                         input logic [63:0] wd, input logic [CW-1:0] rc,
                         input bit exp_acc, input string tag);
    msg_valid_i = mv; msg_cpu_i = mc; msg_src_i = ms; msg_d0_i = m0; msg_d1_i = m1;
    req_valid_i = rv; req_write_i = rw; req_addr_i = ra; req_wdata_i = wd; req_cpu_i = rc;
    #1;
    if (mv) check(msg_accept_o == exp_acc, tag, 64'(msg_accept_o), 64'(exp_acc));
    @(negedge clk);
    msg_valid_i = 1'b0; req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input int c, input string tag);
    rd_q.push_back(mread(a, c));
    rd_tag_q.push_back(tag);
    tick_io(0, '0, '0, '0, '0, 1, 0, a, '0, CW'(c), 0, tag);
  endtask

  task automatic model_write(input logic [11:0] a, input logic [63:0] wd, input int c);
    if (a == 12'h400) vec_m = wd[5:0];
    else if (a == 12'h310) busy_m[c] = wd[5];
    else if (a[11:8] == 4'd2 && a[2:0] == 3'd0 && a[7:3] < NC) busy_m[a[7:3]] = wd[5];
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] wd, input int c);
    tick_io(0, '0, '0, '0, '0, 1, 1, a, wd, CW'(c), 0, "wr");
    model_write(a, wd, c);
  endtask

  task automatic msg(input int c, input logic [4:0] s, input logic [63:0] a0,
                     input logic [63:0] a1, input string tag);
    bit acc;
    acc = !busy_m[c];
    if (acc) begin
      post_q.push_back({CW'(c), vec_m});
      post_tag_q.push_back(tag);
    end
    tick_io(1, CW'(c), s, a0, a1, 0, 0, '0, '0, '0, acc, tag);
    if (acc) begin
      busy_m[c] = 1'b1; src_m[c] = s; d0_m[c] = a0; d1_m[c] = a1;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && rsp_valid_o) begin
      if (rd_q.size() == 0) check(0, "R12 unexpected response", rsp_rdata_o, 64'd0);
      else begin
        logic [63:0] e;
        string t;
        e = rd_q.pop_front();
        t = rd_tag_q.pop_front();
        check(rsp_rdata_o == e, t, rsp_rdata_o, e);
      end
    end
    if (rst_ni && post_valid_o) begin
      if (post_q.size() == 0) check(0, "R4 unexpected post", {post_cpu_o, post_vec_o}, 64'd0);
      else begin
        logic [CW+5:0] e;
        string t;
        e = post_q.pop_front();
        t = post_tag_q.pop_front();
        check({post_cpu_o, post_vec_o} == e, {t, " post"}, 64'({post_cpu_o, post_vec_o}), 64'(e));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      busy_m[i] = 0; src_m[i] = 0; d0_m[i] = 0; d1_m[i] = 0;
    end
    vec_m = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(post_valid_o == 0 && rsp_valid_o == 0, "R1 outputs idle", 64'(post_valid_o), 64'd0);
    rd(12'h200, 0, "R1 stat0");
    rd(12'h238, 0, "R1 stat7");
    rd(12'h010, 0, "R1 data0 of cpu2");
    rd(12'h400, 0, "R1 vector");

    // R9 vector register keeps bits 5:0 only
    wr(12'h400, 64'hFFFF_FFFF_FFFF_FFEA, 0);
    rd(12'h400, 0, "R9 vector 6 bits");
    wr(12'h400, 64'h15, 0);
    rd(12'h400, 0, "R9 vector readback");

    // R2 R4 capture into a free slot
    msg(3, 5'h11, 64'hA5A5_0000_1111_0003, 64'h5A5A_0000_2222_0003, "R2 accept cpu3");
    rd(12'h018, 0, "R7 data0 cpu3");
    rd(12'h118, 0, "R7 data1 cpu3");
    rd(12'h218, 0, "R5 stat cpu3 busy bit5 src");

    // R3 refusal leaves slot unchanged
    msg(3, 5'h02, 64'hDEAD, 64'hBEEF, "R3 refuse busy cpu3");
    rd(12'h018, 0, "R3 data0 kept");
    rd(12'h118, 0, "R3 data1 kept");
    rd(12'h218, 0, "R3 stat kept");

    // R8 alias views follow req_cpu_i
    rd(12'h300, 3, "R8 alias data0");
    rd(12'h308, 3, "R8 alias data1");
    rd(12'h310, 3, "R8 alias stat");
    rd(12'h310, 4, "R8 alias stat other cpu");

    // R6 busy write takes bit 5 only
    wr(12'h218, 64'h0000_0000_0000_001F, 0);
    rd(12'h218, 0, "R6 busy cleared src kept");
    wr(12'h218, 64'h0000_0000_0000_0020, 0);
    rd(12'h218, 0, "R6 busy set src kept");
    wr(12'h218, 64'h0, 0);

    // R2 slot reusable after software frees it; R9 vector change reaches posts
    wr(12'h400, 64'h2C, 0);
    msg(3, 5'h07, 64'h1234, 64'h5678, "R2 accept after free");
    rd(12'h300, 3, "R2 new data0 via alias");
    msg(1, 5'h1E, 64'hFFFF_0000_FFFF_0000, 64'h0F0F, "R9 post uses new vector");

    // R10 data words not writable; unmapped reads zero
    wr(12'h008, 64'hCAFE, 0);
    wr(12'h108, 64'hCAFE, 0);
    wr(12'h300, 64'hCAFE, 1);
    rd(12'h008, 0, "R10 data0 cpu1 unchanged");
    rd(12'h108, 0, "R10 data1 cpu1 unchanged");
    rd(12'h500, 0, "R10 unmapped zero");
    rd(12'h21C, 0, "R10 misaligned zero");

    // R11 capture wins over a same-cycle busy clear
    post_q.push_back({CW'(5), vec_m});
    post_tag_q.push_back("R11 capture vs write");
    tick_io(1, CW'(5), 5'h0A, 64'h55, 64'h66, 1, 1, 12'h228, 64'h0, '0, 1, "R11 accept");
    busy_m[5] = 1; src_m[5] = 5'h0A; d0_m[5] = 64'h55; d1_m[5] = 64'h66;
    rd(12'h228, 0, "R11 slot busy with new src");

    // R8 alias write clears the requester's slot
    wr(12'h310, 64'h0, 5);
    rd(12'h228, 0, "R8 alias write cleared cpu5");

    // R12 read overlapping a capture returns old state
    rd_q.push_back(stat_word(6));
    rd_tag_q.push_back("R12 old state on overlap");
    post_q.push_back({CW'(6), vec_m});
    post_tag_q.push_back("R12 overlap");
    tick_io(1, CW'(6), 5'h13, 64'h77, 64'h88, 1, 0, 12'h230, '0, '0, 1, "R12 accept");
    busy_m[6] = 1; src_m[6] = 5'h13; d0_m[6] = 64'h77; d1_m[6] = 64'h88;
    rd(12'h230, 0, "R12 new state next read");

    repeat (3) @(negedge clk);
    check(rd_q.size() == 0, "R12 pending responses", 64'(rd_q.size()), 64'd0);
    check(post_q.size() == 0, "R4 pending posts", 64'(post_q.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule